// File: doc/BRIEF.md
# ATA PIO Register Cycle Engine

This block runs a single programmed-I/O bus cycle on a parallel ATA cable each time a host request arrives. The host supplies a 5-bit register selector, a direction flag, write data and a start strobe. The engine then drives the chip selects, the device address lines and the read or write strobe in the required order. It holds the strobe low for as long as the device pulls IORDY low, and it returns a one-cycle done pulse. For reads, the data word comes back with that pulse.

The selector packs the address and the chip selects together, so a host can keep one constant per taskfile register and pass it through unchanged. Bus timing comes from the PIO mode (0 to 4) set for each attached device. Setup, strobe-active and full-cycle lengths are kept in nanoseconds and turned into clock counts from the clock period parameter. A cycle to the data register uses the timing of the device it addresses. Every other register uses the slower mode of the devices that are present. A device that never raises IORDY ends the cycle after a bounded wait, with an error flag set.

Top module: `ata_pio_cycle_engine`

## Requirements
- R1: After reset and whenever no cycle is in progress, both chip selects and both strobes are high, DA is 0, the data driver enable is low and done is low.
- R2: Selector bit 0 drives CS0n, bit 1 drives CS1n and bits 4:2 drive DA[2:0]. The selector is shown, with both strobes high, for ceil(setup_ns/CLK_NS) clocks (at least 1) before a strobe falls, and it stays unchanged until done.
- R3: A read lowers only DIORn and a write lowers only DIOWn, each for ceil(active_ns/CLK_NS) clocks when IORDY is high.
- R4: Once the active time has run out, the strobe stays low until IORDY is sampled high. It rises on the clock edge at which IORDY is seen high.
- R5: After the strobe rises, done pulses for exactly one clock after a recovery of max(1, cycle - active - setup) clocks, with each term in clocks.
- R6: During a write, the data enable is high and the write word is on the data output from the first setup clock until done.
- R7: For a read, the data word is captured on the edge at which DIORn is released, and it is held on the read data output.
- R8: Mode timings (setup/active/cycle, in ns) are 0: 70/165/600, 1: 50/125/383, 2: 30/100/240, 3: 30/80/180, 4: 25/70/120. The wait-state output for modes 0 to 4 is 3, 2, 2, 1, 1, and it is 3 after reset.
- R9: A cycle with selector 0x02 (the data register) uses the mode of the device chosen by data_dev. Any other selector uses the lower-numbered mode of device 0 and device 1, and uses device 1 only when dev1_present is high.
- R10: A configured mode value above 4 is treated as mode 0.
- R11: If IORDY is still low IORDY_TIMEOUT clocks after the active time ends, the strobe is released anyway and the error flag is high together with done. A cycle that completes normally gives an error flag of 0.
- R12: A start strobe that arrives while a cycle is in progress is ignored. It changes neither the bus signals nor the timing, and it produces no extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode_dev0 | input | 3 | PIO mode of device 0 |
| cfg_mode_dev1 | input | 3 | PIO mode of device 1 |
| dev1_present | input | 1 | Device 1 is attached |
| data_dev | input | 1 | Device addressed by data-register cycles |
| req_start | input | 1 | Start a cycle (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 5 | Register selector {DA[2:0], CS1n, CS0n} |
| req_wdata | input | 16 | Write word |
| req_done | output | 1 | One-clock end-of-cycle pulse |
| req_err | output | 1 | IORDY timeout in the last cycle |
| req_rdata | output | 16 | Captured read word |
| cyc_wait_states | output | 2 | Wait states of the mode in use |
| bus_cs0_n | output | 1 | Chip select 0, active low |
| bus_cs1_n | output | 1 | Chip select 1, active low |
| bus_da | output | 3 | Device address |
| bus_dior_n | output | 1 | Read strobe, active low |
| bus_diow_n | output | 1 | Write strobe, active low |
| bus_dd_out | output | 16 | Data toward the device |
| bus_dd_oe | output | 1 | Data driver enable |
| bus_dd_in | input | 16 | Data from the device |
| bus_iordy | input | 1 | Device ready |

## Verification
Two events can land on the same clock edge: the end of the active count and the rising of IORDY. In one case IORDY is already high, and the release must happen exactly at the count boundary. In the other case IORDY rises later, and the strobe must rise on the edge that first sees it. The bench sets IORDY high on a chosen low-strobe clock and changes the bus read data on every low clock. The length of the low phase and the captured word then show which edge released the strobe. The timeout expiry is tested against IORDY staying low, and it must give an error flag with the expected low length. A start strobe is also sent in the middle of a cycle, and the bench confirms that it leaves the address, the timing and the done count unchanged.

// File: rtl/ata_pio_cycle_engine.sv
module ata_pio_cycle_engine #(
  parameter int CLK_NS        = 8,
  parameter int IORDY_TIMEOUT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_mode_dev0,
  input  logic [2:0]  cfg_mode_dev1,
  input  logic        dev1_present,
  input  logic        data_dev,
  input  logic        req_start,
  input  logic        req_write,
  input  logic [4:0]  req_sel,
  input  logic [15:0] req_wdata,
  output logic        req_done,
  output logic        req_err,
  output logic [15:0] req_rdata,
  output logic [1:0]  cyc_wait_states,
  output logic        bus_cs0_n,
  output logic        bus_cs1_n,
  output logic [2:0]  bus_da,
  output logic        bus_dior_n,
  output logic        bus_diow_n,
  output logic [15:0] bus_dd_out,
  output logic        bus_dd_oe,
  input  logic [15:0] bus_dd_in,
  input  logic        bus_iordy
);

  localparam int MAX_CLKS = (600 + CLK_NS - 1) / CLK_NS + 1;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);
  localparam int TO_W     = $clog2(IORDY_TIMEOUT + 1);
  localparam logic [4:0] SEL_IDLE = 5'b00011;
  localparam logic [4:0] SEL_DATA = 5'h02;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACTIVE, S_RECOV} state_t;

  function automatic logic [2:0] norm(input logic [2:0] m);
    return (m > 3'd4) ? 3'd0 : m;
  endfunction

  function automatic int to_clks(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int setup_ns(input logic [2:0] m);
    case (m)
      3'd1: return 50;
      3'd2: return 30;
      3'd3: return 30;
      3'd4: return 25;
      default: return 70;
    endcase
  endfunction

  function automatic int active_ns(input logic [2:0] m);
    case (m)
      3'd1: return 125;
      3'd2: return 100;
      3'd3: return 80;
      3'd4: return 70;
      default: return 165;
    endcase
  endfunction

  function automatic int cycle_ns(input logic [2:0] m);
    case (m)
      3'd1: return 383;
      3'd2: return 240;
      3'd3: return 180;
      3'd4: return 120;
      default: return 600;
    endcase
  endfunction

  function automatic int recov_clks(input logic [2:0] m);
    int r;
    r = to_clks(cycle_ns(m)) - to_clks(active_ns(m)) - to_clks(setup_ns(m));
    return (r < 1) ? 1 : r;
  endfunction

  function automatic logic [1:0] wait_states(input logic [2:0] m);
    if (m == 3'd0) return 2'd3;
    if (m <= 3'd2) return 2'd2;
    return 2'd1;
  endfunction

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic [TO_W-1:0]  tcnt;
  logic [2:0]       mode_q;
  logic [4:0]       sel_q;
  logic             wr_q;
  logic [15:0]      wdata_q;

  logic [2:0] m0, m1, slow_mode, eff_mode;
  assign m0        = norm(cfg_mode_dev0);
  assign m1        = norm(cfg_mode_dev1);
  assign slow_mode = (dev1_present && (m1 < m0)) ? m1 : m0;
  assign eff_mode  = (req_sel == SEL_DATA) ? (data_dev ? m1 : m0) : slow_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st              <= S_IDLE;
      cnt             <= '0;
      tcnt            <= '0;
      mode_q          <= 3'd0;
      sel_q           <= SEL_IDLE;
      wr_q            <= 1'b0;
      wdata_q         <= '0;
      req_done        <= 1'b0;
      req_err         <= 1'b0;
      req_rdata       <= '0;
      cyc_wait_states <= 2'd3;
    end else begin
      req_done <= 1'b0;
      case (st)
        S_IDLE: if (req_start) begin
          st              <= S_SETUP;
          sel_q           <= req_sel;
          wr_q            <= req_write;
          wdata_q         <= req_wdata;
          mode_q          <= eff_mode;
          cyc_wait_states <= wait_states(eff_mode);
          req_err         <= 1'b0;
          cnt             <= CNT_W'(to_clks(setup_ns(eff_mode)) - 1);
        end
        S_SETUP: begin
          if (cnt == '0) begin
            st   <= S_ACTIVE;
            cnt  <= CNT_W'(to_clks(active_ns(mode_q)) - 1);
            tcnt <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ACTIVE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (bus_iordy || tcnt == TO_W'(IORDY_TIMEOUT - 1)) begin
            st  <= S_RECOV;
            cnt <= CNT_W'(recov_clks(mode_q) - 1);
            if (!bus_iordy) req_err <= 1'b1;
            if (!wr_q) req_rdata <= bus_dd_in;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            st       <= S_IDLE;
            req_done <= 1'b1;
            sel_q    <= SEL_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign bus_cs0_n  = sel_q[0];
  assign bus_cs1_n  = sel_q[1];
  assign bus_da     = sel_q[4:2];
  assign bus_dior_n = !(st == S_ACTIVE && !wr_q);
  assign bus_diow_n = !(st == S_ACTIVE && wr_q);
  assign bus_dd_oe  = (st != S_IDLE) && wr_q;
  assign bus_dd_out = wdata_q;

endmodule

// File: rtl/ata_pio_cycle_engine_chk.sv
module ata_pio_cycle_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_done,
  input logic       req_err,
  input logic       bus_cs0_n,
  input logic       bus_cs1_n,
  input logic [2:0] bus_da,
  input logic       bus_dior_n,
  input logic       bus_diow_n,
  input logic       bus_dd_oe,
  input logic       bus_iordy
);
  logic       strobe_low;
  logic [4:0] addr;
  assign strobe_low = !bus_dior_n || !bus_diow_n;
  assign addr       = {bus_da, bus_cs1_n, bus_cs0_n};

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(!bus_dior_n && !bus_diow_n)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (strobe_low && $past(strobe_low)) |-> $stable(addr)); // R2
  AST_ADDR_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_dior_n) || $fell(bus_diow_n) |-> $stable(addr)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) req_done |=> !req_done); // R5
  AST_RELEASE_ON_IORDY: assert property (@(posedge clk) disable iff (!rst_n) ($rose(bus_dior_n) || $rose(bus_diow_n)) |-> ($past(bus_iordy) || req_err)); // R4
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) !bus_diow_n |-> bus_dd_oe); // R6
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) req_done |-> (bus_cs0_n && bus_cs1_n && bus_dior_n && bus_diow_n && !bus_dd_oe)); // R1
endmodule

bind ata_pio_cycle_engine ata_pio_cycle_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_done(req_done), .req_err(req_err),
  .bus_cs0_n(bus_cs0_n), .bus_cs1_n(bus_cs1_n), .bus_da(bus_da),
  .bus_dior_n(bus_dior_n), .bus_diow_n(bus_diow_n), .bus_dd_oe(bus_dd_oe),
  .bus_iordy(bus_iordy)
);

// File: tb/ata_pio_cycle_engine_bench.sv
`timescale 1ns/1ps
module ata_pio_cycle_engine_bench;
  localparam int CLK_NS = 8;
  localparam int TMO    = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_mode_dev0 = 3'd0, cfg_mode_dev1 = 3'd0;
  logic dev1_present = 1'b0, data_dev = 1'b0;
  logic req_start = 1'b0, req_write = 1'b0;
  logic [4:0] req_sel = 5'd0;
  logic [15:0] req_wdata = 16'd0, bus_dd_in = 16'd0;
  logic bus_iordy = 1'b1;
  logic req_done, req_err, bus_cs0_n, bus_cs1_n, bus_dior_n, bus_diow_n, bus_dd_oe;
  logic [15:0] req_rdata, bus_dd_out;
  logic [1:0] cyc_wait_states;
  logic [2:0] bus_da;

  ata_pio_cycle_engine #(.CLK_NS(CLK_NS), .IORDY_TIMEOUT(TMO)) u_ata_pio_cycle_engine (
    .clk(clk), .rst_n(rst_n), .cfg_mode_dev0(cfg_mode_dev0), .cfg_mode_dev1(cfg_mode_dev1),
    .dev1_present(dev1_present), .data_dev(data_dev), .req_start(req_start),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata), .req_done(req_done),
    .req_err(req_err), .req_rdata(req_rdata), .cyc_wait_states(cyc_wait_states),
    .bus_cs0_n(bus_cs0_n), .bus_cs1_n(bus_cs1_n), .bus_da(bus_da), .bus_dior_n(bus_dior_n),
    .bus_diow_n(bus_diow_n), .bus_dd_out(bus_dd_out), .bus_dd_oe(bus_dd_oe),
    .bus_dd_in(bus_dd_in), .bus_iordy(bus_iordy));

  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  localparam int SET_NS [5] = '{70, 50, 30, 30, 25};
  localparam int ACT_NS [5] = '{165, 125, 100, 80, 70};
  localparam int CYC_NS [5] = '{600, 383, 240, 180, 120};
  localparam int WS     [5] = '{3, 2, 2, 1, 1};

  function automatic int ck(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int e_set(input int m); return ck(SET_NS[m]); endfunction
  function automatic int e_act(input int m); return ck(ACT_NS[m]); endfunction
  function automatic int e_rec(input int m);
    int r;
    r = ck(CYC_NS[m]) - ck(ACT_NS[m]) - ck(SET_NS[m]);
    return (r < 1) ? 1 : r;
  endfunction

  // {sel[4:0], wr, wdata[15:0], mode0[2:0], mode1[2:0], dev1_present, data_dev, expected_mode[2:0]}
  localparam logic [32:0] VECS [8] = '{
    {5'h02, 1'b0, 16'h0000, 3'd4, 3'd0, 1'b1, 1'b0, 3'd4}, // R9 data reg, own device mode
    {5'h02, 1'b1, 16'hBEEF, 3'd4, 3'd1, 1'b1, 1'b1, 3'd1}, // R9 data reg, device 1
    {5'h1E, 1'b1, 16'h00EC, 3'd4, 3'd2, 1'b1, 1'b0, 3'd2}, // R9 command, slower device
    {5'h0A, 1'b0, 16'h0000, 3'd3, 3'd0, 1'b0, 1'b0, 3'd3}, // R9 device 1 absent
    {5'h01, 1'b1, 16'h0004, 3'd0, 3'd4, 1'b1, 1'b0, 3'd0}, // R9 control, device 0 slower
    {5'h16, 1'b0, 16'h0000, 3'd7, 3'd4, 1'b0, 1'b0, 3'd0}, // R10 invalid mode
    {5'h02, 1'b0, 16'h0000, 3'd2, 3'd6, 1'b1, 1'b1, 3'd0}, // R10 invalid mode, data reg
    {5'h06, 1'b1, 16'h5A5A, 3'd4, 3'd5, 1'b1, 1'b0, 3'd0}  // R10 invalid mode in min
  };

  int s, a, r, err, rd, addr_bad, wd_bad, rlow, wlow;

  // hold: 0 = IORDY high throughout, >0 = IORDY rises on that low clock, <0 = never
  task automatic run_cycle(input logic [4:0] sel, input logic wr, input logic [15:0] wdata,
                           input int hold, input bit poke);
    int guard;
    bit fin;
    @(negedge clk);
    req_sel = sel; req_write = wr; req_wdata = wdata; req_start = 1'b1;
    bus_iordy = (hold == 0);
    @(negedge clk);
    req_start = 1'b0;
    s = 0; a = 0; r = 0; err = 0; rd = 0; addr_bad = 0; wd_bad = 0; rlow = 0; wlow = 0;
    guard = 0; fin = 0;
    while (!fin && guard < 5000) begin
      req_start = 1'b0;
      if (req_done) begin
        fin = 1; err = int'(req_err); rd = int'(req_rdata);
      end else begin
        if ({bus_da, bus_cs1_n, bus_cs0_n} != sel) addr_bad++;
        if (wr && (!bus_dd_oe || bus_dd_out != wdata)) wd_bad++;
        if (!bus_dior_n || !bus_diow_n) begin
          a++;
          if (!bus_dior_n) rlow++; else wlow++;
          bus_dd_in = 16'hA500 + 16'(a);
          if (hold > 0 && a == hold) bus_iordy = 1'b1;
        end else if (a == 0) begin
          s++;
          if (poke && s == 2) begin
            req_start = 1'b1; req_sel = 5'h1E; req_write = !wr;
          end
        end else begin
          r++;
          bus_dd_in = 16'hFFFF;
        end
        guard++;
        @(negedge clk);
      end
    end
    req_start = 1'b0;
    bus_iordy = 1'b1;
    if (!fin) check("R5", "done never seen", 0, 1);
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "cs0_n", int'(bus_cs0_n), 1);
    check("R1", "cs1_n", int'(bus_cs1_n), 1);
    check("R1", "strobes", int'({bus_dior_n, bus_diow_n}), 3);
    check("R1", "oe/done", int'({bus_dd_oe, req_done}), 0);
    check("R8", "reset wait states", int'(cyc_wait_states), 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic [32:0] v;
      int m;
      v = VECS[i];
      cfg_mode_dev0 = v[10:8]; cfg_mode_dev1 = v[7:5];
      dev1_present = v[4]; data_dev = v[3];
      m = int'(v[2:0]);
      run_cycle(v[32:28], v[27], v[26:11], 0, 1'b0);
      check("R2", $sformatf("vec%0d setup clocks", i), s, e_set(m));
      check("R3", $sformatf("vec%0d active clocks", i), a, e_act(m));
      check("R5", $sformatf("vec%0d recovery clocks", i), r, e_rec(m));
      check("R2", $sformatf("vec%0d address mismatches", i), addr_bad, 0);
      check("R3", $sformatf("vec%0d wrong strobe", i), v[27] ? rlow : wlow, 0);
      check("R11", $sformatf("vec%0d error flag", i), err, 0);
      check("R8", $sformatf("vec%0d wait states", i), int'(cyc_wait_states), WS[m]);
      if (v[27]) check("R6", $sformatf("vec%0d write data", i), wd_bad, 0);
      else check("R7", $sformatf("vec%0d read data", i), rd, 16'hA500 + e_act(m));
      @(negedge clk);
      check("R1", $sformatf("vec%0d idle bus", i),
            int'({bus_cs0_n, bus_cs1_n, bus_dior_n, bus_diow_n, bus_dd_oe, req_done}), 6'b111100);
    end

    // R4 IORDY stretching, mode 4 read
    cfg_mode_dev0 = 3'd4; cfg_mode_dev1 = 3'd4; dev1_present = 1'b0; data_dev = 1'b0;
    run_cycle(5'h1E, 1'b0, 16'h0, 15, 1'b0);
    check("R4", "stretched low clocks", a, 15);
    check("R4", "setup unchanged", s, e_set(4));
    check("R5", "recovery after stretch", r, e_rec(4));
    check("R7", "capture at release", rd, 16'hA500 + 15);

    // R4 IORDY rises on the last active clock: no stretch
    run_cycle(5'h0E, 1'b1, 16'h1234, e_act(4), 1'b0);
    check("R4", "boundary low clocks", a, e_act(4));

    // R11 timeout
    run_cycle(5'h12, 1'b0, 16'h0, -1, 1'b0);
    check("R11", "timeout low clocks", a, e_act(4) - 1 + TMO);
    check("R11", "timeout error flag", err, 1);
    run_cycle(5'h12, 1'b1, 16'h7777, 0, 1'b0);
    check("R11", "error cleared next cycle", err, 0);

    // R12 start during cycle ignored
    run_cycle(5'h0A, 1'b0, 16'h0, 0, 1'b1);
    check("R12", "setup clocks", s, e_set(4));
    check("R12", "active clocks", a, e_act(4));
    check("R12", "recovery clocks", r, e_rec(4));
    check("R12", "address held", addr_bad, 0);
    check("R12", "write strobe untouched", wlow, 0);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (req_done || !bus_cs0_n || !bus_cs1_n) extra++;
      end
      check("R12", "no extra cycle", extra, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule